// File: doc/BRIEF.md
# Quad Element Swizzle Unit

This unit rearranges elements of a 128-entry element register file. The permutation is controlled by an immediate and works on groups of four consecutive elements. One command names a source start index, a destination start index, an 8-bit selector immediate and a group count. For every group the unit first pulls the four source elements into a holding buffer. It then writes four destination elements, and each destination lane picks one buffered lane through its own 2-bit selector.

Group `g` covers source elements `rs1+4g .. rs1+4g+3` and destination elements `rd+4g .. rd+4g+3`. All index sums wrap modulo the register file size. Groups run strictly in order, so a later group sees what an earlier group wrote.

The register file is split into four single-write, single-read banks, one per low index bit pair. A preload port fills the file and an inspect port reads it back while no command is running.

Top module: `quad_swizzle`

## Requirements
- R1: While reset is high and after it is released, `done` stays low until a command completes.
- R2: A command with group count VL touches exactly the elements `rd+4g+k` for g in 0..VL-1 and k in 0..3. Every other element keeps its value.
- R3: Destination lane k of a group (element `rd+4g+k`) receives buffered source lane `imm[2k+1:2k]`, so lane 0 is selected by imm bits 1:0 and lane 3 by bits 7:6.
- R4: All four source elements of a group are read before any of that group's destinations are written. A group whose destinations overlap its own sources therefore uses the old source values. Later groups read values that earlier groups have already written.
- R5: If `start` is sampled at clock edge E0 while idle, `done` is high for exactly one cycle, following edge E0+2*VL.
- R6: With VL = 0 no element is written, and `done` pulses in the cycle right after the start edge.
- R7: An immediate of 0xE4 with `rd` equal to `rs1` leaves every element unchanged.
- R8: Element indices wrap modulo 128, so a group starting at 126 uses elements 126, 127, 0 and 1.
- R9: While a command is running, `start` and `pre_we` are ignored. Neither the command in flight nor the register file contents change because of them.
- R10: While idle, `pre_we` writes `pre_data` to `pre_addr` at the clock edge. `insp_data` shows element `insp_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a command (sampled while idle) |
| rd | input | 7 | Destination start element index |
| rs1 | input | 7 | Source start element index |
| imm | input | 8 | Four packed 2-bit lane selectors, lane 0 in bits 1:0 |
| vl | input | 6 | Number of four-element groups |
| done | output | 1 | One-cycle completion pulse |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 7 | Preload element index |
| pre_data | input | 16 | Preload element value |
| insp_addr | input | 7 | Inspect element index |
| insp_data | output | 16 | Inspected element value, one cycle after the address |

## Verification
The embedded assertions check the sequencing on every cycle:
- `done` is a single-cycle pulse.
- Each read phase is followed by a write phase, and each write phase follows a read phase.
- A zero-length command finishes at once.
- The latched command fields do not move while the unit is busy.

The data behaviour can only be shown by the bench's scenarios, which compare the whole file against an arithmetic model. This covers lane selection for every immediate, overlap between source and destination within and across groups, index wrap-around, the identity immediate, and commands or preloads issued while the unit is busy being ignored.

// File: rtl/qsw_pkg.sv
package qsw_pkg;
  localparam int LANES = 4;
  localparam int SELW  = 2;
  localparam int IMMW  = LANES * SELW;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } qsw_state_e;
endpackage

// File: rtl/qsw_bank.sv
module qsw_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qsw_xbar.sv
module qsw_xbar
  import qsw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]                src_lo,
  input  logic [1:0]                dst_lo,
  input  logic [IMMW-1:0]           sel,
  input  logic [LANES-1:0][DW-1:0]  bank_rd,
  output logic [LANES-1:0][DW-1:0]  bank_wr
);
  logic [LANES-1:0][DW-1:0] held;
  logic [LANES-1:0][DW-1:0] lane_out;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [1:0] src_bank;
    logic [1:0] pick;
    assign src_bank    = src_lo + 2'(j);
    assign held[j]     = bank_rd[src_bank];
    assign pick        = sel[SELW*j +: SELW];
    assign lane_out[j] = held[pick];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [1:0] lane;
    assign lane       = 2'(b) - dst_lo;
    assign bank_wr[b] = lane_out[lane];
  end
endmodule

// File: rtl/qsw_ctrl.sv
module qsw_ctrl
  import qsw_pkg::*;
#(
  parameter int AW  = 7,
  parameter int VLW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   rd,
  input  logic [AW-1:0]   rs1,
  input  logic [IMMW-1:0] imm,
  input  logic [VLW-1:0]  vl,
  output logic            busy,
  output logic            rd_phase,
  output logic            wr_phase,
  output logic [AW-1:0]   src_base,
  output logic [AW-1:0]   dst_base,
  output logic [IMMW-1:0] imm_q,
  output logic            done
);
  qsw_state_e           state;
  logic [VLW-1:0]       grp;
  logic [VLW-1:0]       vl_q;
  logic [AW-1:0]        rs1_q, rd_q, off_q;
  logic [VLW-1:0]       grp_nxt;

  assign grp_nxt  = grp + 1'b1;
  assign busy     = (state != ST_IDLE);
  assign rd_phase = (state == ST_READ);
  assign wr_phase = (state == ST_WRITE);
  assign src_base = rs1_q + off_q;
  assign dst_base = rd_q + off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      grp   <= '0;
      vl_q  <= '0;
      rs1_q <= '0;
      rd_q  <= '0;
      off_q <= '0;
      imm_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          rs1_q <= rs1;
          rd_q  <= rd;
          imm_q <= imm;
          vl_q  <= vl;
          grp   <= '0;
          off_q <= '0;
          if (vl == '0) done  <= 1'b1;
          else          state <= ST_READ;
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          grp   <= grp_nxt;
          off_q <= off_q + AW'(LANES);
          if (grp_nxt == vl_q) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
    rd_phase |=> wr_phase);

  // R4
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    wr_phase |-> $past(rd_phase));

  // R6
  zero_len_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vl == '0) |=> (done && !busy));

  // R9
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(imm_q) && $stable(vl_q) && $stable(rs1_q) && $stable(rd_q)));
endmodule

// File: rtl/quad_swizzle.sv
module quad_swizzle
  import qsw_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NENT = 128,
  parameter int VLW  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [$clog2(NENT)-1:0] rd,
  input  logic [$clog2(NENT)-1:0] rs1,
  input  logic [7:0]              imm,
  input  logic [VLW-1:0]          vl,
  output logic                    done,
  input  logic                    pre_we,
  input  logic [$clog2(NENT)-1:0] pre_addr,
  input  logic [DW-1:0]           pre_data,
  input  logic [$clog2(NENT)-1:0] insp_addr,
  output logic [DW-1:0]           insp_data
);
  localparam int AW     = $clog2(NENT);
  localparam int BDEPTH = NENT / LANES;
  localparam int RW     = AW - 2;

  logic                    busy, rd_phase, wr_phase;
  logic [AW-1:0]           src_base, dst_base;
  logic [IMMW-1:0]         imm_q;
  logic [LANES-1:0][DW-1:0] bank_rd, bank_wr;
  logic [1:0]              insp_sel_q;

  qsw_ctrl #(.AW(AW), .VLW(VLW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd       (rd),
    .rs1      (rs1),
    .imm      (imm),
    .vl       (vl),
    .busy     (busy),
    .rd_phase (rd_phase),
    .wr_phase (wr_phase),
    .src_base (src_base),
    .dst_base (dst_base),
    .imm_q    (imm_q),
    .done     (done)
  );

  qsw_xbar #(.DW(DW)) u_xbar (
    .src_lo  (src_base[1:0]),
    .dst_lo  (dst_base[1:0]),
    .sel     (imm_q),
    .bank_rd (bank_rd),
    .bank_wr (bank_wr)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [1:0]    src_lane, dst_lane;
    logic [AW-1:0] src_idx, dst_idx;
    logic          we;
    logic [RW-1:0] waddr, raddr;
    logic [DW-1:0] wdata;

    assign src_lane = 2'(b) - src_base[1:0];
    assign dst_lane = 2'(b) - dst_base[1:0];
    assign src_idx  = src_base + {{(AW-2){1'b0}}, src_lane};
    assign dst_idx  = dst_base + {{(AW-2){1'b0}}, dst_lane};

    assign we    = wr_phase || (!busy && pre_we && pre_addr[1:0] == 2'(b));
    assign waddr = wr_phase ? dst_idx[AW-1:2] : pre_addr[AW-1:2];
    assign wdata = wr_phase ? bank_wr[b] : pre_data;
    assign raddr = busy ? src_idx[AW-1:2] : insp_addr[AW-1:2];

    qsw_bank #(.DW(DW), .DEPTH(BDEPTH), .AW(RW)) u_bank (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) insp_sel_q <= '0;
    else     insp_sel_q <= insp_addr[1:0];
  end

  assign insp_data = bank_rd[insp_sel_q];
endmodule

// File: tb/test_quad_swizzle.sv
`timescale 1ns/1ps
module test_quad_swizzle;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  rd = '0, rs1 = '0;
  logic [7:0]  imm = '0;
  logic [5:0]  vl = '0;
  logic        done;
  logic        pre_we = 1'b0;
  logic [6:0]  pre_addr = '0;
  logic [15:0] pre_data = '0;
  logic [6:0]  insp_addr = '0;
  logic [15:0] insp_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m [128];

  always #2.5 clk = ~clk;

  quad_swizzle i_quad_swizzle (
    .clk(clk), .rst(rst), .start(start), .rd(rd), .rs1(rs1), .imm(imm),
    .vl(vl), .done(done), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .insp_addr(insp_addr), .insp_data(insp_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_op(int d, int s, int im, int n);
    for (int g = 0; g < n; g++) begin
      logic [15:0] hold [4];
      for (int j = 0; j < 4; j++) hold[j] = m[(s + 4*g + j) % 128];
      for (int k = 0; k < 4; k++) m[(d + 4*g + k) % 128] = hold[(im >> (2*k)) & 3];
    end
  endtask

  task automatic preload_all(int seed);
    for (int a = 0; a < 128; a++) begin
      pre_we = 1'b1; pre_addr = 7'(a);
      pre_data = 16'((a * 40503 + seed * 977 + 11) ^ (a << 9));
      m[a] = pre_data;
      @(negedge clk);
    end
    pre_we = 1'b0;
  endtask

  task automatic verify_all(string tag);
    for (int a = 0; a < 128; a++) begin
      insp_addr = 7'(a);
      @(negedge clk);
      chk($sformatf("%s elem %0d", tag, a), 32'(insp_data), 32'(m[a]));
    end
  endtask

  task automatic run_op(int d, int s, int im, int n, string tag);
    int cnt;
    rd = 7'(d); rs1 = 7'(s); imm = 8'(im); vl = 6'(n); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    chk($sformatf("R5 latency %s", tag), 32'(cnt), 32'(2*n));
    @(negedge clk);
    chk($sformatf("R5 pulse width %s", tag), 32'(done), 32'd0);
    model_op(d, s, im, n);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R1: done low during reset
    chk("R1 done in reset", 32'(done), 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", 32'(done), 32'd0);

    // R10: preload then inspect
    preload_all(1);
    verify_all("R10 preload/inspect");

    // R2 R3: sweep every immediate with varying bases and lengths
    for (int im = 0; im < 256; im++) begin
      if (im % 32 == 0) preload_all(im + 3);
      run_op((im * 11 + 3) % 128, (im * 5) % 128, im, 1 + (im % 4), $sformatf("R3 imm %0h", im));
      verify_all($sformatf("R2 R3 imm %0h", im));
    end

    // R4: in-place reverse and cross-group overlap
    preload_all(7);
    run_op(10, 10, 8'h1B, 4, "R4 in place");
    verify_all("R4 in place");
    run_op(22, 20, 8'h39, 3, "R4 shifted overlap");
    verify_all("R4 shifted overlap");
    run_op(30, 33, 8'h00, 2, "R4 broadcast overlap");
    verify_all("R4 broadcast overlap");

    // R8: wrap-around, including a run longer than the file
    run_op(126, 62, 8'h93, 1, "R8 dst wrap");
    verify_all("R8 dst wrap");
    run_op(100, 120, 8'h4E, 63, "R8 long wrap");
    verify_all("R8 long wrap");

    // R6: zero groups
    run_op(0, 64, 8'h1B, 0, "R6 vl zero");
    verify_all("R6 vl zero");

    // R7: identity immediate
    run_op(40, 40, 8'hE4, 8, "R7 identity");
    verify_all("R7 identity");
    run_op(5, 5, 8'hE4, 32, "R7 identity full");
    verify_all("R7 identity full");

    // R9: start and preload while busy are ignored
    begin
      int cnt;
      rd = 7'd80; rs1 = 7'd16; imm = 8'h2D; vl = 6'd3; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd = 7'd0; rs1 = 7'd0; imm = 8'h00; vl = 6'd9;
      pre_we = 1'b1; pre_addr = 7'd120; pre_data = 16'hDEAD;
      cnt = 0;
      @(negedge clk);
      cnt++;
      start = 1'b0; pre_we = 1'b0;
      while (!done && cnt < 400) begin
        @(negedge clk);
        cnt++;
      end
      chk("R9 latency unaffected", 32'(cnt), 32'd6);
      model_op(80, 16, 8'h2D, 3);
      @(negedge clk);
      chk("R9 no restart", 32'(done), 32'd0);
      repeat (30) @(negedge clk);
      chk("R9 still idle", 32'(done), 32'd0);
      verify_all("R9 busy ignore");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule